// File: doc/BRIEF.md
# DMA Channel Interrupt Status Unit

This block collects interrupt events from eight DMA channels, sorted into five kinds: whole transfer done, block done, source transaction done, destination transaction done, and fault. For each kind it keeps a raw status register with one bit per channel, a mask register, and a masked status view. It also keeps a one-bit-per-kind summary and drives the interrupt lines. The channel engines raise one-cycle event strobes. A global enable for each channel gates only the masked path, so the raw bits always record what happened.

Software reaches the block through a small register port. It has a write strobe, an address, 16-bit write data and a combinational read bus. Mask registers take a data byte together with a per-bit write-enable byte, so software can set or clear one channel's mask bit without reading the register first. Clear registers are write-1-to-clear. Raw registers can be overwritten directly to test interrupt wiring. If a channel raises an event in the same cycle that software clears that bit, the event is kept.

Top module: `chan_irq_hub`

## Requirements
- R1: After reset, every raw and mask bit is 0. Every read returns 0. `irq_kind` is 0, and `irq_any` equals `irq_active_low`.
- R2: A 1 on `ev_strobe[k*8+n]` sets raw bit n of kind k at the next clock edge. Kinds are 0 transfer, 1 block, 2 source transaction, 3 destination transaction, 4 fault. The raw register of kind k reads at address {k[2:0],2'b00} in bits 7:0.
- R3: The masked status of kind k, read at address {k[2:0],2'b10}, equals raw AND mask AND `ch_int_en`. It follows those three with no extra clock.
- R4: A raw bit sets even when its channel's `ch_int_en` bit is 0. That channel's masked status stays 0 until the enable is raised.
- R5: A write to address {k[2:0],2'b01} changes mask bit n to `wdata[n]` only when `wdata[8+n]` is 1. All other mask bits keep their value. The mask reads back at the same address.
- R6: A write to address {k[2:0],2'b11} clears every raw bit of kind k whose `wdata` bit is 1, at the next edge. The masked status of those bits drops with it. Bits written 0 are untouched. This address reads 0.
- R7: Address 5'h14 reads the summary in bits 4:0. Bit k is the OR of kind k's eight masked status bits. `irq_kind` carries the same five bits.
- R8: A write to a raw address replaces that raw register with `wdata[7:0]`.
- R9: When an event strobe and a clear hit the same raw bit in the same cycle, the bit ends set.
- R10: `irq_any` is the OR of the five summary bits. It is inverted when `irq_active_low` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register address (kind in 4:2, function in 1:0) |
| wdata | input | 16 | Write data; mask writes use 15:8 as per-bit enables |
| rdata | output | 16 | Combinational read data for `addr` |
| ev_strobe | input | 40 | Event strobes, bit k*8+n for kind k, channel n |
| ch_int_en | input | 8 | Per-channel global interrupt enable |
| irq_active_low | input | 1 | Output polarity select for `irq_any` |
| irq_kind | output | 5 | Per-kind interrupt lines (summary bits) |
| irq_any | output | 1 | Combined interrupt line |

## Verification
A channel's event strobe and a software clear of the same raw bit can land in the same clock. The bench first sets two raw bits. It then drives a clear of both bits together with a strobe for one of them on the same edge. The raw register must read back with only the strobed bit still set. A companion property checks the other half: a clear with no event in flight always empties the bits it names.

// File: rtl/chan_irq_pkg.sv
package chan_irq_pkg;
  // Number of event kinds; order is fixed because the summary register decodes it
  localparam int KINDS  = 5;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;
  // Write-enable byte position for mask writes
  localparam int WE_LSB = 8;

  localparam logic [2:0] KIND_SUMMARY = 3'd5;

  typedef enum logic [1:0] {
    FN_RAW   = 2'd0,
    FN_MASK  = 2'd1,
    FN_STAT  = 2'd2,
    FN_CLEAR = 2'd3
  } reg_fn_e;
endpackage

// File: rtl/chan_irq_rst_sync.sv
module chan_irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/chan_irq_bank.sv
module chan_irq_bank
  import chan_irq_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raw_wr,
  input  logic              mask_wr,
  input  logic              clr_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_CH-1:0] evt,
  input  logic [NUM_CH-1:0] ch_en,
  output logic [NUM_CH-1:0] raw_q,
  output logic [NUM_CH-1:0] mask_q,
  output logic [NUM_CH-1:0] stat
);
  logic [NUM_CH-1:0] raw_d, mask_d;
  logic              raw_en, mask_en;
  logic [NUM_CH-1:0] wr_bits, wr_sel;

  assign wr_bits = wdata[NUM_CH-1:0];
  assign wr_sel  = wdata[WE_LSB +: NUM_CH];

  // Raw next state: test overwrite, then clear, then events (events win)
  always_comb begin
    raw_d = raw_q;
    if (raw_wr) raw_d = wr_bits;
    if (clr_wr) raw_d = raw_d & ~wr_bits;
    raw_d  = raw_d | evt;
    raw_en = raw_wr | clr_wr | (|evt);
  end

  // Mask next state: per-bit select between old and written value
  always_comb begin
    mask_d  = (mask_q & ~wr_sel) | (wr_bits & wr_sel);
    mask_en = mask_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      raw_q <= '0;
    else if (raw_en) raw_q <= raw_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  assign stat = raw_q & mask_q & ch_en;
endmodule

// File: rtl/chan_irq_merge.sv
module chan_irq_merge
  import chan_irq_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic [KINDS*NUM_CH-1:0] stat_flat,
  input  logic                    irq_active_low,
  output logic [KINDS-1:0]        irq_kind,
  output logic                    irq_any
);
  for (genvar k = 0; k < KINDS; k++) begin : g_kind
    assign irq_kind[k] = |stat_flat[k*NUM_CH +: NUM_CH];
  end

  assign irq_any = (|irq_kind) ^ irq_active_low;
endmodule

// File: rtl/chan_irq_hub.sv
module chan_irq_hub
  import chan_irq_pkg::*;
#(
  parameter int NUM_CH = 8  // at most WE_LSB channels fit the mask write format
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  output logic [DATA_W-1:0]       rdata,
  input  logic [KINDS*NUM_CH-1:0] ev_strobe,
  input  logic [NUM_CH-1:0]       ch_int_en,
  input  logic                    irq_active_low,
  output logic [KINDS-1:0]        irq_kind,
  output logic                    irq_any
);
  localparam int EV_W = KINDS * NUM_CH;

  logic            rst_sync_n;
  logic [2:0]      kind_sel;
  reg_fn_e         fn_sel;
  logic [EV_W-1:0] raw_flat, mask_flat, stat_flat;

  chan_irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign kind_sel = addr[4:2];
  assign fn_sel   = reg_fn_e'(addr[1:0]);

  for (genvar k = 0; k < KINDS; k++) begin : g_bank
    logic hit;
    assign hit = wr_en && (kind_sel == 3'(k));

    chan_irq_bank #(.NUM_CH(NUM_CH)) u_bank (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .raw_wr  (hit && (fn_sel == FN_RAW)),
      .mask_wr (hit && (fn_sel == FN_MASK)),
      .clr_wr  (hit && (fn_sel == FN_CLEAR)),
      .wdata   (wdata),
      .evt     (ev_strobe[k*NUM_CH +: NUM_CH]),
      .ch_en   (ch_int_en),
      .raw_q   (raw_flat[k*NUM_CH +: NUM_CH]),
      .mask_q  (mask_flat[k*NUM_CH +: NUM_CH]),
      .stat    (stat_flat[k*NUM_CH +: NUM_CH])
    );
  end

  chan_irq_merge #(.NUM_CH(NUM_CH)) u_merge (
    .stat_flat      (stat_flat),
    .irq_active_low (irq_active_low),
    .irq_kind       (irq_kind),
    .irq_any        (irq_any)
  );

  // Read path: combinational decode of kind and function
  always_comb begin
    rdata = '0;
    if (kind_sel == KIND_SUMMARY) begin
      if (fn_sel == FN_RAW) rdata[KINDS-1:0] = irq_kind;
    end else if (int'(kind_sel) < KINDS) begin
      case (fn_sel)
        FN_RAW:  rdata[NUM_CH-1:0] = raw_flat[int'(kind_sel)*NUM_CH +: NUM_CH];
        FN_MASK: rdata[NUM_CH-1:0] = mask_flat[int'(kind_sel)*NUM_CH +: NUM_CH];
        FN_STAT: rdata[NUM_CH-1:0] = stat_flat[int'(kind_sel)*NUM_CH +: NUM_CH];
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/chan_irq_hub_chk.sv
module chan_irq_hub_chk
  import chan_irq_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    rst_sync_n,
  input logic                    wr_en,
  input logic [ADDR_W-1:0]       addr,
  input logic [DATA_W-1:0]       wdata,
  input logic [KINDS*NUM_CH-1:0] ev_strobe,
  input logic [NUM_CH-1:0]       ch_int_en,
  input logic                    irq_active_low,
  input logic [KINDS-1:0]        irq_kind,
  input logic                    irq_any,
  input logic [KINDS*NUM_CH-1:0] raw_flat,
  input logic [KINDS*NUM_CH-1:0] mask_flat,
  input logic [KINDS*NUM_CH-1:0] stat_flat
);
  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_sync_n) |-> (raw_flat == '0 && mask_flat == '0 && irq_kind == '0)); // R1

  AST_EVT_SETS_RAW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ev_strobe != '0) |=> ((raw_flat & $past(ev_strobe)) == $past(ev_strobe))); // R2

  AST_STAT_WITHIN_RAW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (stat_flat & ~(raw_flat & mask_flat)) == '0); // R3

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !wr_en |=> $stable(mask_flat)); // R5

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (stat_flat == '0) |-> (irq_any == irq_active_low)); // R10

  AST_ACTIVE_LEVEL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (stat_flat != '0) |-> (irq_any != irq_active_low)); // R10

  for (genvar k = 0; k < KINDS; k++) begin : g_kind
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (wr_en && addr == {3'(k), FN_CLEAR} && ev_strobe[k*NUM_CH +: NUM_CH] == '0)
      |=> ((raw_flat[k*NUM_CH +: NUM_CH] & $past(wdata[NUM_CH-1:0])) == '0)); // R6

    AST_SUMMARY_BIT: assert property (@(posedge clk) disable iff (!rst_sync_n)
      irq_kind[k] == (stat_flat[k*NUM_CH +: NUM_CH] != '0)); // R7

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
        !ch_int_en[c] |-> !stat_flat[k*NUM_CH + c]); // R4
    end
  end
endmodule

bind chan_irq_hub chan_irq_hub_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .rst_sync_n     (rst_sync_n),
  .wr_en          (wr_en),
  .addr           (addr),
  .wdata          (wdata),
  .ev_strobe      (ev_strobe),
  .ch_int_en      (ch_int_en),
  .irq_active_low (irq_active_low),
  .irq_kind       (irq_kind),
  .irq_any        (irq_any),
  .raw_flat       (raw_flat),
  .mask_flat      (mask_flat),
  .stat_flat      (stat_flat)
);

// File: tb/sim_chan_irq_hub.sv
`timescale 1ns/1ps
module sim_chan_irq_hub;
  localparam int NCH = 8;
  localparam int NK  = 5;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [4:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic [NK*NCH-1:0] ev_strobe;
  logic [NCH-1:0]    ch_int_en;
  logic              irq_active_low;
  logic [NK-1:0]     irq_kind;
  logic              irq_any;

  int checks = 0;
  int fails  = 0;

  chan_irq_hub #(.NUM_CH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ev_strobe(ev_strobe), .ch_int_en(ch_int_en),
    .irq_active_low(irq_active_low), .irq_kind(irq_kind), .irq_any(irq_any)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {kind[2:0], channel[2:0], enable[7:0], mask[7:0]}
  localparam logic [21:0] VEC [8] = '{
    {3'd0, 3'd0, 8'hFF, 8'hFF},
    {3'd1, 3'd3, 8'hFF, 8'h00},
    {3'd2, 3'd7, 8'h7F, 8'hFF},
    {3'd3, 3'd5, 8'h20, 8'h20},
    {3'd4, 3'd1, 8'hFF, 8'hFD},
    {3'd4, 3'd6, 8'hC0, 8'h40},
    {3'd0, 3'd2, 8'h00, 8'hFF},
    {3'd1, 3'd4, 8'h10, 8'h10}
  };

  function automatic logic [4:0] adr(input int k, input int f);
    return {3'(k), 2'(f)};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic pulse(input int idx);
    @(negedge clk);
    ev_strobe = '0; ev_strobe[idx] = 1'b1;
    @(negedge clk);
    ev_strobe = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    ev_strobe = '0; ch_int_en = '0; irq_active_low = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    for (int k = 0; k < NK; k++) begin
      rd(adr(k, 0), d); chk("R1 raw after reset", d, 16'h0);
      rd(adr(k, 1), d); chk("R1 mask after reset", d, 16'h0);
      rd(adr(k, 2), d); chk("R1 stat after reset", d, 16'h0);
    end
    rd(5'h14, d); chk("R1 summary after reset", d, 16'h0);
    chk("R1 irq_any idle high-active", {15'h0, irq_any}, 16'h0);
    irq_active_low = 1'b1; #1;
    chk("R1 irq_any idle low-active", {15'h0, irq_any}, 16'h1);
    irq_active_low = 1'b0;

    // Table-driven pass: R2 R3 R4 R7 R10
    for (int i = 0; i < 8; i++) begin
      logic [2:0] k; logic [2:0] c; logic [7:0] en; logic [7:0] msk; logic hit;
      k = VEC[i][21:19]; c = VEC[i][18:16]; en = VEC[i][15:8]; msk = VEC[i][7:0];
      hit = msk[c] & en[c];
      for (int j = 0; j < NK; j++) wr(adr(j, 3), 16'h00FF);
      wr(adr(k, 1), {8'hFF, msk});
      ch_int_en = en;
      pulse(int'(k) * NCH + int'(c));
      rd(adr(k, 0), d); chk("R2 R4 raw bit set by strobe", d, 16'(8'h01 << c));
      rd(adr(k, 2), d); chk("R3 masked status", d, hit ? 16'(8'h01 << c) : 16'h0);
      rd(5'h14, d); chk("R7 summary bit", d, hit ? 16'(5'h01 << k) : 16'h0);
      chk("R7 irq_kind", {11'h0, irq_kind}, hit ? 16'(5'h01 << k) : 16'h0);
      chk("R10 irq_any", {15'h0, irq_any}, {15'h0, hit});
    end
    for (int j = 0; j < NK; j++) wr(adr(j, 3), 16'h00FF);

    // R4: enable low keeps raw, blocks status; raising it exposes status
    wr(adr(3, 1), 16'hFFFF);
    ch_int_en = 8'h00;
    pulse(3 * NCH + 2);
    rd(adr(3, 0), d); chk("R4 raw set with enable low", d, 16'h0004);
    rd(adr(3, 2), d); chk("R4 status blocked", d, 16'h0);
    ch_int_en = 8'h04;
    rd(adr(3, 2), d); chk("R4 status after enable", d, 16'h0004);

    // R10: polarity inversion while active
    irq_active_low = 1'b1; #1;
    chk("R10 irq_any active low", {15'h0, irq_any}, 16'h0);
    irq_active_low = 1'b0;

    // R6: clear with zero bits does nothing; clear address reads zero
    wr(adr(3, 3), 16'h0000);
    rd(adr(3, 0), d); chk("R6 clear of zeros", d, 16'h0004);
    rd(adr(3, 3), d); chk("R6 clear reads zero", d, 16'h0);
    wr(adr(3, 3), 16'h0004);
    rd(adr(3, 0), d); chk("R6 raw cleared", d, 16'h0);
    rd(adr(3, 2), d); chk("R6 status cleared", d, 16'h0);

    // R5: mask writes with per-bit enables
    wr(adr(4, 1), 16'hFFAA);
    wr(adr(4, 1), 16'h0155);
    rd(adr(4, 1), d); chk("R5 single enabled bit", d, 16'h00AB);
    wr(adr(4, 1), 16'h00FF);
    rd(adr(4, 1), d); chk("R5 no enables no change", d, 16'h00AB);

    // R8: direct raw overwrite
    wr(adr(2, 1), 16'hFF00);
    wr(adr(2, 0), 16'h005A);
    rd(adr(2, 0), d); chk("R8 raw overwrite", d, 16'h005A);
    rd(adr(2, 2), d); chk("R8 masked off", d, 16'h0);
    wr(adr(2, 0), 16'h0000);
    rd(adr(2, 0), d); chk("R8 raw overwrite zero", d, 16'h0);

    // R9: event and clear on the same bit in one cycle
    wr(adr(0, 0), 16'h0003);
    @(negedge clk);
    wr_en = 1'b1; addr = adr(0, 3); wdata = 16'h0003;
    ev_strobe = '0; ev_strobe[0] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0; ev_strobe = '0;
    rd(adr(0, 0), d); chk("R9 set wins over clear", d, 16'h0001);

    finish_run();
  end
endmodule